// File: doc/BRIEF.md
# Interrupt Input Request Latch

This block is the input stage of an I/O interrupt controller. It holds one request bit and one source tag for each of its redirection entries. Each cycle it takes at most one level-change request for one pin. The request is a de-assert, an assert or a flip-flop, and it carries a source tag. The stage looks at the pin's trigger mode and at the pin's current request bit. From these it decides whether the request takes effect. An effective request sets the bit, updates the tag and raises a one-cycle delivery pulse that names the entry, so that the dispatch logic can act on it.

Asserts that change nothing are counted. Redundant edge asserts and redundant level asserts have separate saturating counters. A separate end-of-interrupt input clears a pin's request bit and its tag. A tag read port returns the stored tag of any entry.

Top module: `irq_request_latch`

## Requirements
- R1: After reset, all request bits are 0, all tags are 0, both counters are 0 and `deliverValid` is 0.
- R2: An assert request (`reqKind` = 01) on an edge pin (`trigLevel` bit = 0) whose request bit is clear sets that bit. In the next cycle `deliverValid` is 1 for one cycle and `deliverPin` holds the entry index.
- R3: An assert request on an edge pin whose request bit is already set is dropped. The bit and the tag stay as they were, no delivery pulse follows, and the edge counter goes up by one.
- R4: An assert request on a level pin (`trigLevel` bit = 1) always sets the bit and always produces a delivery pulse. If the bit was already set, the level counter also goes up by one.
- R5: A flip-flop request (`reqKind` = 10) always sets the bit and always produces a delivery pulse, whatever the trigger mode and the prior state. It changes neither counter.
- R6: When a request takes effect, the entry's tag becomes `reqTag` if the stored tag was zero. Otherwise the tag becomes 0x8000_0000, which marks that more than one source asserted the entry.
- R7: A de-assert request (`reqKind` = 00) on a level pin clears its bit and keeps its tag, with no delivery pulse. On an edge pin a de-assert request has no effect.
- R8: An end-of-interrupt (`eoiValid`) clears the bit and the tag of `eoiPin`. If a request for the same pin arrives in the same cycle, the clear is applied first and the request then sees a clear bit and a zero tag.
- R9: Each counter stops at its all-ones value.
- R10: A request with a pin index of `NUM_PINS` or higher, or with `reqKind` = 11, changes no bit, no tag and no counter, and produces no delivery pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqPin | input | PIN_W | Entry index of the request |
| reqKind | input | 2 | 00 de-assert, 01 assert, 10 flip-flop, 11 reserved |
| reqTag | input | TAG_W | Source tag of the request |
| trigLevel | input | NUM_PINS | Trigger mode for each entry, 1 = level, 0 = edge |
| eoiValid | input | 1 | End-of-interrupt clear strobe |
| eoiPin | input | PIN_W | Entry index to clear |
| tagSelPin | input | PIN_W | Entry index for the tag read port |
| tagSelData | output | TAG_W | Stored tag of the selected entry (0 when the index is out of range) |
| irrBits | output | NUM_PINS | Request bit of each entry |
| edgeCnt | output | CNT_W | Count of redundant edge asserts |
| levelCnt | output | CNT_W | Count of redundant level asserts |
| deliverValid | output | 1 | One-cycle delivery pulse |
| deliverPin | output | PIN_W | Entry index carried by the delivery pulse |

## Verification
The main function is driven with repeated asserts on the same edge pin and on the same level pin. This separates the dropped edge case from the always-delivered level case, and it shows which counter moves. Flip-flop requests are sent both to a pin whose bit is set and to a pin whose bit is clear, in both trigger modes, to show that they ignore state. A first assert on an untagged entry followed by a second effective assert separates storing the tag from marking it as shared. An end-of-interrupt that coincides with an assert on the same pin shows that the clear happens before the assert is decided. Out-of-range indices, the reserved request kind and a long run of redundant asserts cover the boundaries.

// File: rtl/irl_pkg.sv
package irl_pkg;

  typedef enum logic [1:0] {
    REQ_DEASSERT = 2'b00,
    REQ_ASSERT   = 2'b01,
    REQ_FLIP     = 2'b10,
    REQ_RSVD     = 2'b11
  } reqKind_e;

  // strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic assertPin;  // effective assertion of the request pin
    logic clearPin;   // level de-assert of the request pin
    logic eoiClear;   // end-of-interrupt clear of the eoi pin
    logic bumpEdge;   // redundant edge assert seen
    logic bumpLevel;  // redundant level assert seen
  } strobes_t;

endpackage

// File: rtl/irl_ctrl.sv
module irl_ctrl
  import irl_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                reqValid,
  input  logic [PIN_W-1:0]    reqPin,
  input  logic [1:0]          reqKind,
  input  logic                eoiValid,
  input  logic [PIN_W-1:0]    eoiPin,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic [NUM_PINS-1:0] irrBits,
  output strobes_t            strobes
);

  logic reqOk;
  logic eoiOk;
  logic isLevel;
  logic prevSet;

  always_comb begin
    reqOk   = reqValid && (32'(reqPin) < NUM_PINS);
    eoiOk   = eoiValid && (32'(eoiPin) < NUM_PINS);
    isLevel = reqOk && trigLevel[reqPin];
    // the end-of-interrupt clear is applied before the request is decided
    prevSet = reqOk && irrBits[reqPin] && !(eoiOk && (eoiPin == reqPin));

    strobes          = '0;
    strobes.eoiClear = eoiOk;
    if (reqOk) begin
      unique case (reqKind_e'(reqKind))
        REQ_ASSERT: begin
          if (isLevel) begin
            strobes.assertPin = 1'b1;
            strobes.bumpLevel = prevSet;
          end else if (prevSet) begin
            strobes.bumpEdge = 1'b1;
          end else begin
            strobes.assertPin = 1'b1;
          end
        end
        REQ_FLIP:     strobes.assertPin = 1'b1;
        REQ_DEASSERT: strobes.clearPin  = isLevel;
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/irl_datapath.sv
module irl_datapath
  import irl_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5,
  parameter int TAG_W    = 32,
  parameter int CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [PIN_W-1:0]    reqPin,
  input  logic [PIN_W-1:0]    eoiPin,
  input  logic [TAG_W-1:0]    reqTag,
  input  logic [PIN_W-1:0]    tagSelPin,
  output logic [TAG_W-1:0]    tagSelData,
  output logic [NUM_PINS-1:0] irrBits,
  output logic [CNT_W-1:0]    edgeCnt,
  output logic [CNT_W-1:0]    levelCnt,
  output logic                deliverValid,
  output logic [PIN_W-1:0]    deliverPin
);

  localparam logic [TAG_W-1:0] MULTI_TAG = TAG_W'(1) << (TAG_W - 1);

  logic [NUM_PINS-1:0][TAG_W-1:0] tagFlat;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
    logic             irrQ;
    logic [TAG_W-1:0] tagQ;
    logic             eoiHit;
    logic             setHit;
    logic             clrHit;
    logic [TAG_W-1:0] baseTag;

    assign eoiHit  = strobes.eoiClear  && (eoiPin == PIN_W'(g));
    assign setHit  = strobes.assertPin && (reqPin == PIN_W'(g));
    assign clrHit  = strobes.clearPin  && (reqPin == PIN_W'(g));
    assign baseTag = eoiHit ? '0 : tagQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irrQ <= 1'b0;
        tagQ <= '0;
      end else if (setHit) begin
        irrQ <= 1'b1;
        tagQ <= (baseTag == '0) ? reqTag : MULTI_TAG;
      end else begin
        if (eoiHit || clrHit) irrQ <= 1'b0;
        if (eoiHit)           tagQ <= '0;
      end
    end

    assign irrBits[g] = irrQ;
    assign tagFlat[g] = tagQ;
  end

  assign tagSelData = (32'(tagSelPin) < NUM_PINS) ? tagFlat[tagSelPin] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt      <= '0;
      levelCnt     <= '0;
      deliverValid <= 1'b0;
      deliverPin   <= '0;
    end else begin
      if (strobes.bumpEdge && (edgeCnt != '1))   edgeCnt  <= edgeCnt + CNT_W'(1);
      if (strobes.bumpLevel && (levelCnt != '1)) levelCnt <= levelCnt + CNT_W'(1);
      deliverValid <= strobes.assertPin;
      if (strobes.assertPin) deliverPin <= reqPin;
    end
  end

endmodule

// File: rtl/irq_request_latch.sv
module irq_request_latch
  import irl_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int TAG_W    = 32,
  parameter int CNT_W    = 32,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [PIN_W-1:0]    reqPin,
  input  logic [1:0]          reqKind,
  input  logic [TAG_W-1:0]    reqTag,
  input  logic [NUM_PINS-1:0] trigLevel,
  input  logic                eoiValid,
  input  logic [PIN_W-1:0]    eoiPin,
  input  logic [PIN_W-1:0]    tagSelPin,
  output logic [TAG_W-1:0]    tagSelData,
  output logic [NUM_PINS-1:0] irrBits,
  output logic [CNT_W-1:0]    edgeCnt,
  output logic [CNT_W-1:0]    levelCnt,
  output logic                deliverValid,
  output logic [PIN_W-1:0]    deliverPin
);

  strobes_t strobes;

  irl_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) ctrl_i (
    .reqValid (reqValid),
    .reqPin   (reqPin),
    .reqKind  (reqKind),
    .eoiValid (eoiValid),
    .eoiPin   (eoiPin),
    .trigLevel(trigLevel),
    .irrBits  (irrBits),
    .strobes  (strobes)
  );

  irl_datapath #(
    .NUM_PINS(NUM_PINS), .PIN_W(PIN_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqPin      (reqPin),
    .eoiPin      (eoiPin),
    .reqTag      (reqTag),
    .tagSelPin   (tagSelPin),
    .tagSelData  (tagSelData),
    .irrBits     (irrBits),
    .edgeCnt     (edgeCnt),
    .levelCnt    (levelCnt),
    .deliverValid(deliverValid),
    .deliverPin  (deliverPin)
  );

endmodule

// File: rtl/irl_checker.sv
module irl_checker #(
  parameter int NUM_PINS = 24,
  parameter int CNT_W    = 32,
  parameter int PIN_W    = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [PIN_W-1:0]    reqPin,
  input logic [1:0]          reqKind,
  input logic [NUM_PINS-1:0] trigLevel,
  input logic                eoiValid,
  input logic [PIN_W-1:0]    eoiPin,
  input logic [NUM_PINS-1:0] irrBits,
  input logic [CNT_W-1:0]    edgeCnt,
  input logic [CNT_W-1:0]    levelCnt,
  input logic                deliverValid,
  input logic [PIN_W-1:0]    deliverPin
);

  logic reqInRange;
  logic eoiInRange;
  logic sameCycleClear;
  assign reqInRange     = 32'(reqPin) < NUM_PINS;
  assign eoiInRange     = 32'(eoiPin) < NUM_PINS;
  assign sameCycleClear = eoiValid && eoiInRange && (eoiPin == reqPin);

  // R2: a delivered entry has its request bit set
  p_deliver_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    deliverValid |-> irrBits[deliverPin]);

  // R3: redundant edge assert is dropped and counted
  p_edge_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqInRange && reqKind == 2'b01 && !trigLevel[reqPin]
     && irrBits[reqPin] && !sameCycleClear)
    |=> (!deliverValid && (edgeCnt == $past(edgeCnt) + CNT_W'(1) || (&edgeCnt))));

  // R4: level assert always delivers its entry
  p_level_deliver_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqInRange && reqKind == 2'b01 && trigLevel[reqPin])
    |=> (deliverValid && deliverPin == $past(reqPin)));

  // R5: flip-flop always delivers and leaves the bit set
  p_flip_deliver_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqInRange && reqKind == 2'b10)
    |=> (deliverValid && irrBits[$past(reqPin)]));

  // R8: end-of-interrupt clears the bit
  p_eoi_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && eoiInRange && !(reqValid && reqPin == eoiPin))
    |=> !irrBits[$past(eoiPin)]);

  // R9: counters never move backwards
  p_cnt_mono_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (edgeCnt >= $past(edgeCnt) && levelCnt >= $past(levelCnt)));

  // R10: out-of-range or reserved requests change nothing
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (!reqInRange || reqKind == 2'b11) && !eoiValid)
    |=> (!deliverValid && $stable(irrBits) && $stable(edgeCnt) && $stable(levelCnt)));

endmodule

bind irq_request_latch irl_checker #(
  .NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .PIN_W(PIN_W)
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPin(reqPin), .reqKind(reqKind),
  .trigLevel(trigLevel), .eoiValid(eoiValid), .eoiPin(eoiPin), .irrBits(irrBits),
  .edgeCnt(edgeCnt), .levelCnt(levelCnt), .deliverValid(deliverValid),
  .deliverPin(deliverPin)
);

// File: tb/irq_request_latch_tb.sv
module irq_request_latch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int TW = 32;
  localparam int CW = 4;
  localparam int PW = 5;
  localparam logic [NP-1:0] LEVEL_MAP = 24'hFFF000;  // pins 12..23 level

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [PW-1:0] reqPin = '0;
  logic [1:0] reqKind = '0;
  logic [TW-1:0] reqTag = '0;
  logic [NP-1:0] trigLevel = LEVEL_MAP;
  logic eoiValid = 1'b0;
  logic [PW-1:0] eoiPin = '0;
  logic [PW-1:0] tagSelPin = '0;
  logic [TW-1:0] tagSelData;
  logic [NP-1:0] irrBits;
  logic [CW-1:0] edgeCnt, levelCnt;
  logic deliverValid;
  logic [PW-1:0] deliverPin;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_request_latch #(.NUM_PINS(NP), .TAG_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPin(reqPin), .reqKind(reqKind),
    .reqTag(reqTag), .trigLevel(trigLevel), .eoiValid(eoiValid), .eoiPin(eoiPin),
    .tagSelPin(tagSelPin), .tagSelData(tagSelData), .irrBits(irrBits),
    .edgeCnt(edgeCnt), .levelCnt(levelCnt), .deliverValid(deliverValid),
    .deliverPin(deliverPin)
  );

  typedef struct {
    string         req;
    logic          del;
    logic [PW-1:0] pin;
    logic [NP-1:0] irr;
    logic [TW-1:0] tag;
    logic [CW-1:0] ec;
    logic [CW-1:0] lc;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, kept from the requirements
  logic [NP-1:0] mIrr = '0;
  logic [TW-1:0] mTag [NP];
  logic [CW-1:0] mEdge = '0;
  logic [CW-1:0] mLevel = '0;
  logic [PW-1:0] mDelPin = '0;

  task automatic doOp(input string r, input bit v, input int pin, input logic [1:0] kind,
                      input logic [TW-1:0] tag, input bit ev, input int epin, input int sel);
    exp_t e;
    bit del;
    @(negedge clk);
    reqValid = v; reqPin = PW'(pin); reqKind = kind; reqTag = tag;
    eoiValid = ev; eoiPin = PW'(epin); tagSelPin = PW'(sel);
    del = 1'b0;
    if (ev && epin < NP) begin
      mIrr[epin] = 1'b0;
      mTag[epin] = '0;
    end
    if (v && pin < NP) begin
      bit prev, lvl, eff;
      prev = mIrr[pin];
      lvl  = LEVEL_MAP[pin];
      eff  = (kind == 2'b10) || (kind == 2'b01 && (lvl || !prev));
      if (kind == 2'b01 && !lvl && prev && mEdge != '1) mEdge = mEdge + 1'b1;
      if (kind == 2'b01 && lvl && prev && mLevel != '1) mLevel = mLevel + 1'b1;
      if (kind == 2'b00 && lvl) mIrr[pin] = 1'b0;
      if (eff) begin
        mTag[pin] = (mTag[pin] == '0) ? tag : 32'h8000_0000;
        mIrr[pin] = 1'b1;
        del = 1'b1;
        mDelPin = PW'(pin);
      end
    end
    e.req = r; e.del = del; e.pin = mDelPin; e.irr = mIrr;
    e.tag = (sel < NP) ? mTag[sel] : '0; e.ec = mEdge; e.lc = mLevel;
    expQ.push_back(e);
  endtask

  // monitor: compares one expected item per clock, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (deliverValid !== e.del || (e.del && deliverPin !== e.pin) || irrBits !== e.irr ||
            tagSelData !== e.tag || edgeCnt !== e.ec || levelCnt !== e.lc) begin
          errors++;
          $display("FAIL %s: del=%0b/%0b pin=%0d/%0d irr=%h/%h tag=%h/%h ec=%0d/%0d lc=%0d/%0d",
                   e.req, deliverValid, e.del, deliverPin, e.pin, irrBits, e.irr,
                   tagSelData, e.tag, edgeCnt, e.ec, levelCnt, e.lc);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) mTag[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (irrBits !== '0 || edgeCnt !== '0 || levelCnt !== '0 || deliverValid !== 1'b0 ||
        tagSelData !== '0) begin
      errors++;
      $display("FAIL R1: irr=%h ec=%0d lc=%0d del=%0b tag=%h expected all zero",
               irrBits, edgeCnt, levelCnt, deliverValid, tagSelData);
    end
    rstN = 1'b1;

    doOp("R2 edge first assert",      1, 3, 2'b01, 32'h5, 0, 0, 3);
    doOp("R3 edge redundant",         1, 3, 2'b01, 32'h7, 0, 0, 3);
    doOp("R5 R6 flip on set edge",    1, 3, 2'b10, 32'h9, 0, 0, 3);
    doOp("R8 eoi clears",             0, 0, 2'b00, 32'h0, 1, 3, 3);
    doOp("R4 level first",            1, 15, 2'b01, 32'h11, 0, 0, 15);
    doOp("R4 R6 level redundant",     1, 15, 2'b01, 32'h22, 0, 0, 15);
    doOp("R7 level deassert",         1, 15, 2'b00, 32'h0, 0, 0, 15);
    doOp("R2 edge pin4",              1, 4, 2'b01, 32'h44, 0, 0, 4);
    doOp("R7 edge deassert ignored",  1, 4, 2'b00, 32'h0, 0, 0, 4);
    doOp("R10 pin out of range",      1, 26, 2'b01, 32'h66, 0, 0, 4);
    doOp("R10 reserved kind",         1, 5, 2'b11, 32'h55, 0, 0, 5);
    doOp("R8 eoi and assert same pin", 1, 4, 2'b01, 32'h77, 1, 4, 4);
    for (int k = 0; k < 17; k++) doOp("R9 edge saturate", 1, 4, 2'b01, 32'h1, 0, 0, 4);
    doOp("R5 flip clear edge pin0",   1, 0, 2'b10, 32'h0A, 0, 0, 0);
    doOp("R4 level pin23",            1, 23, 2'b01, 32'h0B, 0, 0, 23);
    doOp("R5 flip set level pin23",   1, 23, 2'b10, 32'h0C, 0, 0, 23);
    doOp("R8 eoi pin23",              0, 0, 2'b00, 32'h0, 1, 23, 23);
    doOp("R6 retag after eoi",        1, 23, 2'b01, 32'h0D, 0, 0, 23);
    doOp("R1 idle",                   0, 0, 2'b00, 32'h0, 0, 0, 0);
    @(negedge clk);
    reqValid = 1'b0; eoiValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule